// File: doc/BRIEF.md
# Flash Sector Protection Unit

This unit keeps one write/erase protection bit for each sector of a small flash information bank and screens the program and erase requests aimed at that bank. Software reads and writes the bits through a simple register port at one word offset. A request to a protected sector is refused in the same cycle on a reject flag. A request to an unprotected sector is passed on as a start pulse to the program engine or to the erase engine.

Two conditions override software. First, the bits are frozen while any of the three engines (single program, burst program, erase) reports busy. Second, a sector that the secure-zone mask marks is always treated as protected. The value that reads back and that guards requests is the stored bit ORed with the mask. A sector that leaves the secure zone therefore returns to its stored setting.

Top module: `flash_sect_guard`

## Requirements
- R1: After reset every stored protection bit is 1, so a read at offset 0x0B0 with a zero secure mask returns 0x0000000F.
- R2: Bits 31:4 of the register always read 0, and the write data in those bits has no effect.
- R3: A write at offset 0x0B0 while the program, burst and erase idle inputs are all 1 loads write-data bit n into the protection bit of sector n (n = 0..3), visible from the next cycle.
- R4: A write at offset 0x0B0 while any idle input is 0 leaves every bit unchanged and raises `wr_ignored` in that same cycle only.
- R5: A sector whose `secure_mask` bit is 1 reads as protected and blocks requests whatever its stored bit. Software writing 0 to it does not clear that. When the mask bit returns to 0, the stored value applies again.
- R6: A request (`req_valid`=1) to a sector whose effective bit is 1 raises `req_reject` in the same cycle and gives no start pulse.
- R7: A request to an unprotected sector raises `start_pgm` when `req_erase`=0 and `start_erase` when `req_erase`=1, in the same cycle, and no reject.
- R8: A read at any offset other than 0x0B0 returns 0. A write there changes no bit and raises no `wr_ignored`.
- R9: A request in the same cycle as an accepted write is judged against the bits held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pgm_idle | input | 1 | Single-program engine idle |
| burst_idle | input | 1 | Burst-program engine idle |
| erase_idle | input | 1 | Erase engine idle |
| secure_mask | input | 4 | Per-sector secure-zone flag |
| req_valid | input | 1 | Operation request |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_sector | input | 2 | Target sector |
| start_pgm | output | 1 | Program start pulse |
| start_erase | output | 1 | Erase start pulse |
| req_reject | output | 1 | Request refused |
| wr_ignored | output | 1 | Write dropped because an engine is busy |

## Verification
The bench makes a register write and a request fall in the same cycle, and it also makes a dropped write and a request coincide. In the same-cycle case the write changes the guarded sector's bit, and the bench expects the request to be judged against the pre-write value. It expects the new value to apply only on the following cycle. A behavioural model of the bits is compared with every output on every clock, over directed steps and a random stream that mixes writes, busy engines, mask changes and requests.

// File: rtl/flash_sect_guard.sv
module flash_sect_guard #(
  parameter int            NSECT   = 4,
  parameter int            AW      = 12,
  parameter int            DW      = 32,
  parameter logic [AW-1:0] REG_OFS = 12'h0B0,
  localparam int           SW      = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             pgm_idle,
  input  logic             burst_idle,
  input  logic             erase_idle,
  input  logic [NSECT-1:0] secure_mask,
  input  logic             req_valid,
  input  logic             req_erase,
  input  logic [SW-1:0]    req_sector,
  output logic             start_pgm,
  output logic             start_erase,
  output logic             req_reject,
  output logic             wr_ignored
);

  logic [NSECT-1:0] prot_q;
  logic [NSECT-1:0] eff;
  logic             hit, wr_hit, all_idle, blocked;

  assign hit      = bus_sel && (bus_addr == REG_OFS);
  assign wr_hit   = hit && bus_wr;
  assign all_idle = pgm_idle && burst_idle && erase_idle;
  assign eff      = prot_q | secure_mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  prot_q <= '1;
    else if (wr_hit && all_idle) prot_q <= bus_wdata[NSECT-1:0];

  assign bus_rdata   = hit ? {{(DW-NSECT){1'b0}}, eff} : '0;
  assign wr_ignored  = wr_hit && !all_idle;
  assign blocked     = eff[req_sector];
  assign req_reject  = req_valid && blocked;
  assign start_pgm   = req_valid && !blocked && !req_erase;
  assign start_erase = req_valid && !blocked && req_erase;

  // R3
  write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && all_idle) |=> (prot_q == $past(bus_wdata[NSECT-1:0])));

  // R4
  write_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !all_idle) |=> $stable(prot_q));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NSECT] == '0);

  // R5
  secure_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((bus_rdata[NSECT-1:0] & secure_mask) == secure_mask));

  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones({start_pgm, start_erase, req_reject}) == 1));

  // R7
  no_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(start_pgm || start_erase || req_reject));

  // R8
  other_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != REG_OFS) |-> (bus_rdata == '0 && !wr_ignored));

endmodule

// File: tb/flash_sect_guard_test.sv
`timescale 1ns/1ps
module flash_sect_guard_test;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        pgm_idle = 1, burst_idle = 1, erase_idle = 1;
  logic [3:0]  secure_mask = 0;
  logic        req_valid = 0, req_erase = 0;
  logic [1:0]  req_sector = 0;
  logic        start_pgm, start_erase, req_reject, wr_ignored;

  int checks = 0, errors = 0;
  logic [3:0] m_prot = 4'hF;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_sect_guard uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pgm_idle(pgm_idle), .burst_idle(burst_idle), .erase_idle(erase_idle),
    .secure_mask(secure_mask), .req_valid(req_valid), .req_erase(req_erase),
    .req_sector(req_sector), .start_pgm(start_pgm), .start_erase(start_erase),
    .req_reject(req_reject), .wr_ignored(wr_ignored));

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic sel, wr, input logic [11:0] addr, input logic [31:0] wd,
                      input logic [2:0] idle, input logic [3:0] msk,
                      input logic rv, re, input logic [1:0] rs, input string tag);
    logic [3:0] e;
    logic       hit, busy, blk;
    @(posedge clk); #1;
    bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    {pgm_idle, burst_idle, erase_idle} = idle; secure_mask = msk;
    req_valid = rv; req_erase = re; req_sector = rs;
    @(negedge clk);
    e    = m_prot | msk;
    hit  = sel && addr == 12'h0B0;
    busy = idle != 3'b111;
    blk  = e[rs];
    cmp(tag, "rdata", bus_rdata, hit ? {28'h0, e} : 32'h0);
    cmp(tag, "reject", {31'h0, req_reject}, {31'h0, rv && blk});
    cmp(tag, "start_pgm", {31'h0, start_pgm}, {31'h0, rv && !blk && !re});
    cmp(tag, "start_erase", {31'h0, start_erase}, {31'h0, rv && !blk && re});
    cmp(tag, "wr_ignored", {31'h0, wr_ignored}, {31'h0, hit && wr && busy});
    if (hit && wr && !busy) m_prot = wd[3:0];
  endtask

  task automatic rd(input logic [3:0] msk, input string tag);
    step(1, 0, 12'h0B0, 0, 3'b111, msk, 0, 0, 0, tag);
  endtask
  task automatic wrt(input logic [31:0] wd, input logic [2:0] idle, input logic [3:0] msk, input string tag);
    step(1, 1, 12'h0B0, wd, idle, msk, 0, 0, 0, tag);
  endtask
  task automatic rq(input logic re, input logic [1:0] rs, input logic [3:0] msk, input string tag);
    step(0, 0, 0, 0, 3'b111, msk, 1, re, rs, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(0, "R1");
    for (int s = 0; s < 4; s++) begin rq(0, s[1:0], 0, "R6"); rq(1, s[1:0], 0, "R6"); end
    wrt(32'h5, 3'b111, 0, "R3"); rd(0, "R3");
    wrt(32'hFFFF_FFFA, 3'b111, 0, "R2"); rd(0, "R2");
    rq(0, 0, 0, "R7"); rq(1, 2, 0, "R7"); rq(1, 1, 0, "R6"); rq(0, 3, 0, "R6");
    wrt(32'h0, 3'b011, 0, "R4"); rd(0, "R4");
    wrt(32'h0, 3'b101, 0, "R4"); rd(0, "R4");
    wrt(32'h0, 3'b110, 0, "R4"); rd(0, "R4");
    step(1, 1, 12'h0B0, 0, 3'b100, 0, 1, 0, 0, "R4");
    rd(4'b0001, "R5"); rq(0, 0, 4'b0001, "R5"); rd(0, "R5"); rq(0, 0, 0, "R5");
    wrt(32'h0, 3'b111, 4'hF, "R5"); rd(4'hF, "R5"); rq(1, 3, 4'hF, "R5");
    rd(0, "R5"); rq(1, 3, 0, "R5");
    step(1, 1, 12'h0B4, 32'hF, 3'b111, 0, 0, 0, 0, "R8"); rd(0, "R8");
    step(1, 0, 12'h0B4, 0, 3'b111, 0, 0, 0, 0, "R8");
    step(1, 1, 12'h0B0, 32'hF, 3'b111, 0, 1, 0, 0, "R9");
    rq(0, 0, 0, "R9");
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r = $urandom;
      step(r[0], r[1], r[2] ? 12'h0B0 : 12'h0B4, $urandom,
           r[5:3] | {2'b00, r[6]} | {r[7], 2'b00}, r[11:8] & r[15:12],
           r[16], r[17], r[19:18], "R3");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule